// File: doc/BRIEF.md
# Mersenne-Modulus Residue-Quotient Encoder

This block turns an unsigned binary word into a code pair: the residue R = X mod m and the quotient Q = floor(X/m), where the modulus is m = 2^k − 1. Because 2^k leaves a remainder of 1 when divided by m, the word can be cut into a low slice (the bits below k) and a high slice (the bits from k upward). The two slices are summed, and the high slice adds straight into the quotient. The fold repeats until the running sum is below 2m. A single compare against m then subtracts m from the residue and adds one to the quotient when needed. No divider is used, only adders and one comparator.

A typical use is next to an arithmetic datapath, such as a sum-of-absolute-difference accumulator, to produce check codes for its results. The number of fold stages is derived at elaboration from the data width and k. The output may be registered, with a valid strobe, or left combinational. A parameter chooses the variant, and registered is the default.

Top module: `rq_encoder`

## Requirements
- R1: For every accepted input X, the residue output equals X mod m and is strictly less than m (m = 2^MOD_K − 1, 63 by default).
- R2: For every accepted input X, the quotient output equals floor(X/m), so that quotient·m + residue = X over the full DATA_W-bit input range.
- R3: An input equal to m gives residue 0 and quotient 1.
- R4: An input of 0 gives residue 0 and quotient 0.
- R5: Inputs that are whole multiples of m, including the largest input 2^DATA_W − 1 (4095 = 65·63), give residue 0 and the exact multiple as quotient.
- R6: An input of m − 1 gives residue m − 1 and quotient 0, with no correction applied.
- R7: In the registered variant, out_valid is high in the cycle after each cycle where in_valid is high, and low after each cycle where in_valid is low. The result belongs to the input accepted in that earlier cycle.
- R8: While rst_n is low at a clock edge, out_valid, out_res and out_quo are cleared to zero, whatever in_valid and in_data carry.
- R9: In the registered variant, a cycle with in_valid low leaves out_res and out_quo unchanged, whatever in_data carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_data as a word to encode |
| in_data | input | DATA_W | Unsigned word X |
| out_valid | output | 1 | Marks out_res and out_quo as a fresh result |
| out_res | output | MOD_K | Residue X mod m |
| out_quo | output | DATA_W−MOD_K+1 | Quotient floor(X/m) |

## Verification
The bench builds the block with its defaults: a 12-bit input, k = 6 so m = 63, and the registered variant. At this size every one of the 4096 input values can be fed through and compared. That sweep reaches the double fold needed at the top of the range, where the first sum lands exactly on 2m, and the exact-multiple and just-below-m corner cases. The idle cycles between results show that the strobe drops and that the held outputs do not follow the data lines.

// File: rtl/rq_pkg.sv
// Shared helpers for the residue-quotient encoder.
// Assumes the modulus exponent is at least 2 and below the data width.
package rq_pkg;

    // Number of split-and-add folds needed so the running sum ends below 2m.
    function automatic int fold_count(input int data_w, input int mod_k);
        longint bound;
        longint modv;
        int     n;
        modv  = (longint'(1) << mod_k) - 1;
        bound = (longint'(1) << data_w) - 1;
        bound = modv + (bound >> mod_k);
        n     = 1;
        while (bound >= 2 * modv && n < 32) begin
            bound = modv + (bound >> mod_k);
            n++;
        end
        return n;
    endfunction

    // Quotient width that holds floor((2^data_w - 1) / (2^mod_k - 1)).
    function automatic int quo_width(input int data_w, input int mod_k);
        return data_w - mod_k + 1;
    endfunction

endpackage

// File: rtl/rq_fold_stage.sv
// One split-and-add fold: the value is cut at bit MOD_K, the high slice is
// added back onto the low slice (since 2^k = m + 1) and also into the quotient.
// Assumes the value never grows, so the output keeps the input width.
module rq_fold_stage #(
    parameter int DATA_W = 12,
    parameter int MOD_K  = 6,
    parameter int QUO_W  = DATA_W - MOD_K + 1
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [QUO_W-1:0]  quo_i,
    output logic [DATA_W-1:0] val_o,
    output logic [QUO_W-1:0]  quo_o
);
    localparam int HI_W = DATA_W - MOD_K;

    logic [MOD_K-1:0] lo_slice;
    logic [HI_W-1:0]  hi_slice;

    // Split the value and fold the high slice into both running terms.
    always_comb begin
        lo_slice = val_i[MOD_K-1:0];
        hi_slice = val_i[DATA_W-1:MOD_K];
        val_o    = {{HI_W{1'b0}}, lo_slice} + {{MOD_K{1'b0}}, hi_slice};
        quo_o    = quo_i + {{(QUO_W-HI_W){1'b0}}, hi_slice};
    end
endmodule

// File: rtl/rq_final_correct.sv
// Final correction: once the running sum is below 2m, one compare against m
// decides whether m is taken off the residue and one added to the quotient.
module rq_final_correct #(
    parameter int DATA_W = 12,
    parameter int MOD_K  = 6,
    parameter int QUO_W  = DATA_W - MOD_K + 1
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [QUO_W-1:0]  quo_i,
    output logic [MOD_K-1:0]  res_o,
    output logic [QUO_W-1:0]  quo_o
);
    localparam logic [DATA_W-1:0] MOD_W = {{(DATA_W-MOD_K){1'b0}}, {MOD_K{1'b1}}};

    logic              reached;
    logic [DATA_W-1:0] trimmed;

    // Compare against m and apply at most one subtraction.
    always_comb begin
        reached = (val_i >= MOD_W);
        trimmed = reached ? (val_i - MOD_W) : val_i;
        res_o   = trimmed[MOD_K-1:0];
        quo_o   = quo_i + {{(QUO_W-1){1'b0}}, reached};
    end
endmodule

// File: rtl/rq_encoder_core.sv
// Combinational residue-quotient core: a generated chain of fold stages
// followed by one correction step. The chain length comes from the widths.
module rq_encoder_core #(
    parameter int DATA_W = 12,
    parameter int MOD_K  = 6,
    parameter int QUO_W  = DATA_W - MOD_K + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [MOD_K-1:0]  res_o,
    output logic [QUO_W-1:0]  quo_o
);
    localparam int NUM_FOLDS = rq_pkg::fold_count(DATA_W, MOD_K);

    logic [DATA_W-1:0] val_chain [NUM_FOLDS+1];
    logic [QUO_W-1:0]  quo_chain [NUM_FOLDS+1];

    // Seed the chain with the raw word and an empty quotient.
    always_comb begin
        val_chain[0] = data_i;
        quo_chain[0] = '0;
    end

    for (genvar g = 0; g < NUM_FOLDS; g++) begin : g_fold
        rq_fold_stage #(
            .DATA_W (DATA_W),
            .MOD_K  (MOD_K),
            .QUO_W  (QUO_W)
        ) u_fold (
            .val_i (val_chain[g]),
            .quo_i (quo_chain[g]),
            .val_o (val_chain[g+1]),
            .quo_o (quo_chain[g+1])
        );
    end

    rq_final_correct #(
        .DATA_W (DATA_W),
        .MOD_K  (MOD_K),
        .QUO_W  (QUO_W)
    ) u_correct (
        .val_i (val_chain[NUM_FOLDS]),
        .quo_i (quo_chain[NUM_FOLDS]),
        .res_o (res_o),
        .quo_o (quo_o)
    );
endmodule

// File: rtl/rq_encoder.sv
// Top of the residue-quotient encoder for modulus 2^MOD_K - 1.
// REGISTERED = 1 puts one register stage with a valid strobe after the core;
// REGISTERED = 0 passes the core result and the strobe straight through.
// Assumes 2 <= MOD_K < DATA_W and unsigned input words.
module rq_encoder #(
    parameter int DATA_W     = 12,
    parameter int MOD_K      = 6,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    output logic                          out_valid,
    output logic [MOD_K-1:0]              out_res,
    output logic [DATA_W-MOD_K:0]         out_quo
);
    localparam int QUO_W   = rq_pkg::quo_width(DATA_W, MOD_K);
    localparam int MOD_INT = (1 << MOD_K) - 1;

    logic [MOD_K-1:0] core_res;
    logic [QUO_W-1:0] core_quo;

    rq_encoder_core #(
        .DATA_W (DATA_W),
        .MOD_K  (MOD_K),
        .QUO_W  (QUO_W)
    ) u_core (
        .data_i (in_data),
        .res_o  (core_res),
        .quo_o  (core_quo)
    );

    if (REGISTERED) begin : g_reg
        // Capture the code pair and strobe; clear all of it under reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_res   <= '0;
                out_quo   <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    out_res <= core_res;
                    out_quo <= core_quo;
                end
            end
        end

        a_r1_res_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (int'(out_res) < MOD_INT));

        a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (int'(out_quo) * MOD_INT + int'(out_res) == int'($past(in_data))));

        a_r3_exact_mod: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && int'(in_data) == MOD_INT) |=> (out_res == '0 && int'(out_quo) == 1));

        a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_res) && $stable(out_quo)));
    end else begin : g_comb
        // Pass the core result and the strobe through without delay.
        always_comb begin
            out_valid = in_valid;
            out_res   = core_res;
            out_quo   = core_quo;
        end

        a_r1_res_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (int'(out_res) < MOD_INT));

        a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (int'(out_quo) * MOD_INT + int'(out_res) == int'(in_data)));
    end
endmodule

// File: tb/rq_encoder_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected code pairs, the monitor pops
// and compares them whenever the design raises out_valid.
module rq_encoder_tb;
    localparam int DATA_W = 12;
    localparam int MOD_K  = 6;
    localparam int MODV   = 63;
    localparam int QUO_W  = DATA_W - MOD_K + 1;

    typedef struct {
        int unsigned data;
        int unsigned res;
        int unsigned quo;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [MOD_K-1:0]  out_res;
    logic [QUO_W-1:0]  out_quo;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;

    rq_encoder #(.DATA_W(DATA_W), .MOD_K(MOD_K), .REGISTERED(1'b1)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_res   (out_res),
        .out_quo   (out_quo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Drive one word and queue its expected code pair.
    task automatic send(input int unsigned d);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DATA_W'(d);
        e.data = d;
        e.res  = d % MODV;
        e.quo  = d / MODV;
        if (d == 0)               e.tag = "R4";
        else if (d == MODV)       e.tag = "R3";
        else if (d == MODV - 1)   e.tag = "R6";
        else if (d % MODV == 0)   e.tag = "R5";
        else                      e.tag = "R2";
        exp_q.push_back(e);
    endtask

    // Drop in_valid and put junk on the data lines.
    task automatic go_idle(input int unsigned junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = DATA_W'(junk);
    endtask

    // Monitor: pop the oldest expectation on every valid result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(out_res) == int'(e.res), {"R1 residue ", e.tag},
                    int'(out_res), int'(e.res));
                chk(int'(out_quo) == int'(e.quo), {"R2 quotient ", e.tag},
                    int'(out_quo), int'(e.quo));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R8: reset clears outputs even with a live input.
        in_valid = 1'b1;
        in_data  = '1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        chk(out_res == '0, "R8 out_res in reset", int'(out_res), 0);
        chk(out_quo == '0, "R8 out_quo in reset", int'(out_quo), 0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 no valid without input", int'(out_valid), 0);

        // Named corners first: R4, R6, R3, R5.
        send(0);
        send(MODV - 1);
        send(MODV);
        send(2 * MODV);
        send(4095);

        // R9 and R7: after 100 (R=37, Q=1) an idle cycle keeps the pair.
        send(100);
        go_idle(7);
        go_idle(4000);
        chk(out_valid == 1'b0, "R7 valid drops when idle", int'(out_valid), 0);
        chk(int'(out_res) == 37, "R9 residue held", int'(out_res), 37);
        chk(int'(out_quo) == 1, "R9 quotient held", int'(out_quo), 1);

        // R1 and R2: exhaustive sweep over every input word.
        for (int v = 0; v < (1 << DATA_W); v++) begin
            send(v);
        end
        go_idle(0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7 every input produced a result", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule